// File: doc/BRIEF.md
# Small 8-bit Instruction Sequencer

This block is a multi-cycle execution core for a narrow slice of a classic 8-bit accumulator machine. It owns the architectural registers A, X, Y, the stack pointer, the status byte and the 16-bit program counter. It drives a synchronous byte-wide memory port: an address and a read strobe issued in one cycle return their byte on `mem_rdata` in the next cycle, and a write completes in the cycle it is issued.

Each instruction runs through a small cycle sequence. The sequence fetches the opcode, classifies it, reads the operand bytes its addressing mode needs (implied, immediate, zero page or absolute), and then executes. Every supported opcode has an exact byte length and an exact cycle count. The last operand byte of a load, of a bit test and of a jump is consumed in the same cycle that fetches the next opcode. Any opcode outside the supported set freezes the core until the next reset.

A system integrator ties `boot_addr` to the start address. The memory sits behind the port and answers every read one cycle late. The register view outputs show the architectural state after each instruction completes.

Top module: `seq8_core`

## Requirements
- R1: While `rst_n` is low, the core loads PC from `boot_addr`, SP with 0xFD, the status byte with 0x24, and A, X and Y with zero, and it drops `illegal_op`. In the first cycle after release it fetches the opcode at `boot_addr`.
- R2: Opcode lengths and cycle counts are fixed, counted as the cycles from one `op_fetch` pulse to the next. 0x4C takes 3 bytes and 3 cycles, and 0x20 takes 3 bytes and 6 cycles. 0x24, 0x85 and 0x86 take 2 bytes and 3 cycles. 0xA9 and 0xA2 take 2 bytes and 2 cycles. 0x18, 0x38 and 0xEA take 1 byte and 2 cycles.
- R3: Opcodes 0xA9 and 0xA2 load the byte that follows them into A and X respectively. N (status bit 7) takes bit 7 of that byte, and Z (status bit 1) is set exactly when the byte is zero. No other status bit changes.
- R4: Opcodes 0x85 and 0x86 write A and X respectively to address 0x00nn, where nn is the operand byte. They leave the status byte unchanged.
- R5: Opcode 0x24 reads address 0x00nn. N takes bit 7 of the memory byte, V (status bit 6) takes bit 6, and Z is set exactly when A AND the byte is zero. A and C are unchanged.
- R6: Opcode 0x38 sets C (status bit 0) and 0x18 clears it. Opcode 0xEA changes no register except PC.
- R7: Opcode 0x4C takes a little-endian operand (low byte first), and the next opcode fetch goes to that address.
- R8: Opcode 0x20 first computes the address of the byte after the instruction. It writes that address's high byte to 0x0100+SP and decrements SP, then writes its low byte to 0x0100+SP and decrements SP. The next opcode fetch goes to the little-endian target.
- R9: Any other opcode raises `illegal_op`, which stays high until reset. While it is high the core performs no memory reads or writes, and A, X and the status byte hold their values.
- R10: `mem_rd` and `mem_wr` are never high together. `op_fetch` is high only in cycles that read an opcode, and it never appears in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_addr | input | 16 | PC value loaded during reset |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the previous cycle's read |
| op_fetch | output | 1 | Current read is an opcode fetch |
| illegal_op | output | 1 | Sticky unsupported-opcode indication |
| view_a | output | 8 | Accumulator |
| view_x | output | 8 | X index register |
| view_y | output | 8 | Y index register |
| view_sp | output | 8 | Stack pointer |
| view_p | output | 8 | Status byte |
| view_pc | output | 16 | Program counter |

## Verification
Some properties are checked by assertions on every cycle:

- read and write strobes never collide;
- opcode fetches are never back to back;
- the frozen state after an unsupported opcode is sticky and silent on the bus;
- a write never disturbs the status byte;
- each stack write moves SP down by exactly one.

Other behaviour is shown only by the directed scenarios:

- exact per-opcode cycle counts and byte lengths, seen through the spacing and addresses of `op_fetch`;
- flag results for specific operand values;
- the return-address bytes placed on the stack;
- the jump targets.

// File: rtl/seq8_pkg.sv
`timescale 1ns/1ps
package seq8_pkg;

   typedef enum logic [3:0] {
      K_NONE,
      K_ILL,
      K_NOP,
      K_CLC,
      K_SEC,
      K_LDA,
      K_LDX,
      K_STA,
      K_STX,
      K_BIT,
      K_JMP,
      K_JSR
   } op_kind_t;

   typedef enum logic [2:0] {
      S_T0,
      S_T1,
      S_T2,
      S_T3,
      S_T4,
      S_T5,
      S_HALT
   } seq_state_t;

   // opcode byte to operation class; everything unlisted is unsupported
   function automatic op_kind_t classify(input logic [7:0] code);
      case (code)
         8'hEA:   classify = K_NOP;
         8'h18:   classify = K_CLC;
         8'h38:   classify = K_SEC;
         8'hA9:   classify = K_LDA;
         8'hA2:   classify = K_LDX;
         8'h85:   classify = K_STA;
         8'h86:   classify = K_STX;
         8'h24:   classify = K_BIT;
         8'h4C:   classify = K_JMP;
         8'h20:   classify = K_JSR;
         default: classify = K_ILL;
      endcase
   endfunction

endpackage

// File: rtl/seq8_decode.sv
`timescale 1ns/1ps
module seq8_decode
   import seq8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opcode,
   output op_kind_t          kind
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("seq8_decode: opcode width must be 8");
      end
   endgenerate

   always_comb kind = classify(opcode[7:0]);

endmodule

// File: rtl/seq8_flags.sv
`timescale 1ns/1ps
module seq8_flags
   import seq8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  op_kind_t          kind,
   input  logic [DATA_W-1:0] p_in,
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] p_out
);

   localparam int BIT_N = DATA_W - 1;
   localparam int BIT_V = DATA_W - 2;
   localparam int BIT_Z = 1;
   localparam int BIT_C = 0;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("seq8_flags: status byte needs at least 8 bits");
      end
   endgenerate

   always_comb begin
      p_out = p_in;
      case (kind)
         K_LDA, K_LDX: begin
            p_out[BIT_N] = value[BIT_N];
            p_out[BIT_Z] = (value == '0);
         end
         K_BIT: begin
            p_out[BIT_N] = value[BIT_N];
            p_out[BIT_V] = value[BIT_V];
            p_out[BIT_Z] = ((acc & value) == '0);
         end
         K_CLC:   p_out[BIT_C] = 1'b0;
         K_SEC:   p_out[BIT_C] = 1'b1;
         default: p_out = p_in;
      endcase
   end

endmodule

// File: rtl/seq8_core.sv
`timescale 1ns/1ps
module seq8_core
   import seq8_pkg::*;
#(
   parameter int          DATA_W     = 8,
   parameter int          ADDR_W     = 16,
   parameter logic [7:0]  STACK_PAGE = 8'h01,
   parameter logic [7:0]  SP_INIT    = 8'hFD,
   parameter logic [7:0]  P_INIT     = 8'h24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       boot_addr,
   output logic [15:0]       mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              op_fetch,
   output logic              illegal_op,
   output logic [7:0]        view_a,
   output logic [7:0]        view_x,
   output logic [7:0]        view_y,
   output logic [7:0]        view_sp,
   output logic [7:0]        view_p,
   output logic [15:0]       view_pc
);

   localparam int PAGE_W = ADDR_W - DATA_W;
   localparam logic [PAGE_W-1:0] ZERO_PAGE = '0;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("seq8_core: data path must be 8 bits");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
         $error("seq8_core: address must be two data bytes wide");
      end
   endgenerate

   seq_state_t          state_q, state_d;
   op_kind_t            kind_q, kind_d, pend_q, pend_d, dec_kind, flag_kind;
   logic [ADDR_W-1:0]   pc_q, pc_d, fetch_addr;
   logic [DATA_W-1:0]   sp_q, sp_d, a_q, a_d, x_q, x_d, y_q, p_q, p_d, p_new;
   logic [DATA_W-1:0]   lo_q, lo_d, hi_q, hi_d;
   logic                ill_q, ill_d;

   seq8_decode #(.DATA_W(DATA_W)) u_decode (
      .opcode (mem_rdata),
      .kind   (dec_kind)
   );

   // which operation the status unit evaluates this cycle
   always_comb begin
      case (state_q)
         S_T0:    flag_kind = pend_q;
         S_T1:    flag_kind = dec_kind;
         default: flag_kind = K_NONE;
      endcase
   end

   seq8_flags #(.DATA_W(DATA_W)) u_flags (
      .kind  (flag_kind),
      .p_in  (p_q),
      .value (mem_rdata),
      .acc   (a_q),
      .p_out (p_new)
   );

   // a pending jump takes its high byte straight off the read bus
   assign fetch_addr = (pend_q == K_JMP) ? {mem_rdata, lo_q} : pc_q;

   always_comb begin
      state_d   = state_q;
      kind_d    = kind_q;
      pend_d    = pend_q;
      pc_d      = pc_q;
      sp_d      = sp_q;
      a_d       = a_q;
      x_d       = x_q;
      p_d       = p_q;
      lo_d      = lo_q;
      hi_d      = hi_q;
      ill_d     = ill_q;
      mem_addr  = pc_q;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_wdata = '0;
      op_fetch  = 1'b0;
      case (state_q)
         S_T0: begin
            mem_addr = fetch_addr;
            mem_rd   = 1'b1;
            op_fetch = 1'b1;
            pc_d     = fetch_addr + 1'b1;
            case (pend_q)
               K_LDA: begin
                  a_d = mem_rdata;
                  p_d = p_new;
               end
               K_LDX: begin
                  x_d = mem_rdata;
                  p_d = p_new;
               end
               K_BIT:   p_d = p_new;
               default: ;
            endcase
            pend_d  = K_NONE;
            state_d = S_T1;
         end
         S_T1: begin
            kind_d = dec_kind;
            if (dec_kind == K_ILL) begin
               ill_d   = 1'b1;
               state_d = S_HALT;
            end else begin
               mem_rd = 1'b1;
               case (dec_kind)
                  K_NOP, K_CLC, K_SEC: begin
                     p_d     = p_new;
                     state_d = S_T0;
                  end
                  K_LDA, K_LDX: begin
                     pc_d    = pc_q + 1'b1;
                     pend_d  = dec_kind;
                     state_d = S_T0;
                  end
                  default: begin
                     pc_d    = pc_q + 1'b1;
                     state_d = S_T2;
                  end
               endcase
            end
         end
         S_T2: begin
            state_d = S_T0;
            case (kind_q)
               K_STA: begin
                  mem_addr  = {ZERO_PAGE, mem_rdata};
                  mem_wr    = 1'b1;
                  mem_wdata = a_q;
               end
               K_STX: begin
                  mem_addr  = {ZERO_PAGE, mem_rdata};
                  mem_wr    = 1'b1;
                  mem_wdata = x_q;
               end
               K_BIT: begin
                  mem_addr = {ZERO_PAGE, mem_rdata};
                  mem_rd   = 1'b1;
                  pend_d   = K_BIT;
               end
               K_JMP: begin
                  mem_rd = 1'b1;
                  lo_d   = mem_rdata;
                  pend_d = K_JMP;
               end
               K_JSR: begin
                  mem_rd  = 1'b1;
                  lo_d    = mem_rdata;
                  pc_d    = pc_q + 1'b1;
                  state_d = S_T3;
               end
               default: ;
            endcase
         end
         S_T3: begin
            hi_d      = mem_rdata;
            mem_addr  = {STACK_PAGE, sp_q};
            mem_wr    = 1'b1;
            mem_wdata = pc_q[ADDR_W-1:DATA_W];
            sp_d      = sp_q - 1'b1;
            state_d   = S_T4;
         end
         S_T4: begin
            mem_addr  = {STACK_PAGE, sp_q};
            mem_wr    = 1'b1;
            mem_wdata = pc_q[DATA_W-1:0];
            sp_d      = sp_q - 1'b1;
            state_d   = S_T5;
         end
         S_T5: begin
            pc_d    = {hi_q, lo_q};
            state_d = S_T0;
         end
         default: state_d = S_HALT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_T0;
         kind_q  <= K_NONE;
         pend_q  <= K_NONE;
         pc_q    <= boot_addr;
         sp_q    <= SP_INIT;
         a_q     <= '0;
         x_q     <= '0;
         y_q     <= '0;
         p_q     <= P_INIT;
         lo_q    <= '0;
         hi_q    <= '0;
         ill_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         kind_q  <= kind_d;
         pend_q  <= pend_d;
         pc_q    <= pc_d;
         sp_q    <= sp_d;
         a_q     <= a_d;
         x_q     <= x_d;
         p_q     <= p_d;
         lo_q    <= lo_d;
         hi_q    <= hi_d;
         ill_q   <= ill_d;
      end
   end

   assign illegal_op = ill_q;
   assign view_a     = a_q;
   assign view_x     = x_q;
   assign view_y     = y_q;
   assign view_sp    = sp_q;
   assign view_p     = p_q;
   assign view_pc    = pc_q;

   // R10
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R10
   fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_fetch |=> !op_fetch);

   // R9
   illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |=> illegal_op);

   // R9
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> (!mem_rd && !mem_wr && !op_fetch));

   // R4
   store_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> $stable(view_p));

   // R8
   push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && (mem_addr[15:8] == STACK_PAGE)) |=>
         (view_sp == $past(view_sp) - 8'd1));

endmodule

// File: tb/seq8_core_test.sv
`timescale 1ns/1ps
module seq8_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] boot_addr = 16'h0200;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, op_fetch, illegal_op;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic [7:0]  view_a, view_x, view_y, view_sp, view_p;
   logic [15:0] view_pc;

   int nchk = 0;
   int nfail = 0;

   logic [7:0]  mem [0:4095];
   logic [15:0] f_addr [0:31];
   int          f_cyc  [0:31];
   logic [15:0] w_addr [0:15];
   logic [7:0]  w_data [0:15];
   int          nf, nw, hacc, cyc;

   always #5 clk = ~clk;

   seq8_core uut (
      .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .op_fetch(op_fetch), .illegal_op(illegal_op),
      .view_a(view_a), .view_x(view_x), .view_y(view_y),
      .view_sp(view_sp), .view_p(view_p), .view_pc(view_pc)
   );

   // synchronous memory: read data one cycle later
   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
   end

   // bus activity log
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         nf <= 0; nw <= 0; hacc <= 0;
      end else begin
         if (op_fetch && nf < 32) begin
            f_addr[nf] <= mem_addr; f_cyc[nf] <= cyc; nf <= nf + 1;
         end
         if (mem_wr && nw < 16) begin
            w_addr[nw] <= mem_addr; w_data[nw] <= mem_wdata; nw <= nw + 1;
         end
         if (illegal_op && (mem_rd || mem_wr)) hacc <= hacc + 1;
      end
   end

   initial cyc = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic hold_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
      @(negedge clk);
   endtask

   task automatic poke(input int a, input logic [7:0] v);
      mem[a] <= v;
   endtask

   task automatic release_at(input logic [15:0] pc);
      boot_addr = pc;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_to_halt(input string req);
      int n = 0;
      while (!illegal_op && n < 200) begin
         @(negedge clk);
         n++;
      end
      check(req, "program reached halt", illegal_op, 1);
   endtask

   task automatic t_reset();
      hold_reset();
      poke(16'h0ABC, 8'h02);
      release_at(16'h0ABC);
      check("R1", "pc", view_pc, 16'h0ABC);
      check("R1", "sp", view_sp, 8'hFD);
      check("R1", "p", view_p, 8'h24);
      check("R1", "a/x/y", {view_a, view_x, view_y}, 24'h0);
      check("R1", "illegal", illegal_op, 0);
      check("R1", "first fetch addr", op_fetch ? mem_addr : 16'hFFFF, 16'h0ABC);
      run_to_halt("R1");
   endtask

   task automatic t_loads();
      hold_reset();
      poke(16'h200, 8'hA9); poke(16'h201, 8'h80);
      poke(16'h202, 8'hA2); poke(16'h203, 8'h00);
      poke(16'h204, 8'h02);
      release_at(16'h0200);
      run_to_halt("R3");
      check("R3", "A after LDA 80", view_a, 8'h80);
      check("R3", "X after LDX 00", view_x, 8'h00);
      check("R3", "P Z set N clear", view_p, 8'h26);
      hold_reset();
      poke(16'h200, 8'hA9); poke(16'h201, 8'h00);
      poke(16'h202, 8'hA9); poke(16'h203, 8'h05);
      poke(16'h204, 8'hA2); poke(16'h205, 8'hFF);
      poke(16'h206, 8'h02);
      release_at(16'h0200);
      run_to_halt("R3");
      check("R3", "A after LDA 05", view_a, 8'h05);
      check("R3", "X after LDX FF", view_x, 8'hFF);
      check("R3", "P N set Z clear", view_p, 8'hA4);
   endtask

   task automatic t_stores();
      hold_reset();
      poke(16'h200, 8'h38);
      poke(16'h201, 8'hA2); poke(16'h202, 8'hC3);
      poke(16'h203, 8'hA9); poke(16'h204, 8'h5A);
      poke(16'h205, 8'h85); poke(16'h206, 8'h10);
      poke(16'h207, 8'h86); poke(16'h208, 8'h11);
      poke(16'h209, 8'h02);
      release_at(16'h0200);
      run_to_halt("R4");
      check("R4", "mem[0010]", mem[12'h010], 8'h5A);
      check("R4", "mem[0011]", mem[12'h011], 8'hC3);
      check("R4", "write count", nw, 2);
      check("R4", "first write addr", w_addr[0], 16'h0010);
      check("R4", "second write addr", w_addr[1], 16'h0011);
      check("R4", "P unchanged by stores", view_p, 8'h25);
   endtask

   task automatic t_bit();
      hold_reset();
      poke(16'h020, 8'hC0);
      poke(16'h200, 8'hA9); poke(16'h201, 8'h0F);
      poke(16'h202, 8'h24); poke(16'h203, 8'h20);
      poke(16'h204, 8'h02);
      release_at(16'h0200);
      run_to_halt("R5");
      check("R5", "P after BIT C0", view_p, 8'hE6);
      check("R5", "A unchanged", view_a, 8'h0F);
      hold_reset();
      poke(16'h021, 8'h41);
      poke(16'h200, 8'hA9); poke(16'h201, 8'h0F);
      poke(16'h202, 8'h38);
      poke(16'h203, 8'h24); poke(16'h204, 8'h21);
      poke(16'h205, 8'h02);
      release_at(16'h0200);
      run_to_halt("R5");
      check("R5", "P after BIT 41", view_p, 8'h65);
      check("R5", "A unchanged 2", view_a, 8'h0F);
   endtask

   task automatic t_carry();
      hold_reset();
      poke(16'h200, 8'hA9); poke(16'h201, 8'h80);
      poke(16'h202, 8'h38);
      poke(16'h203, 8'hEA);
      poke(16'h204, 8'h02);
      release_at(16'h0200);
      run_to_halt("R6");
      check("R6", "P after SEC NOP", view_p, 8'hA5);
      check("R6", "A kept across NOP", view_a, 8'h80);
      hold_reset();
      poke(16'h200, 8'h38);
      poke(16'h201, 8'h18);
      poke(16'h202, 8'hEA);
      poke(16'h203, 8'h02);
      release_at(16'h0200);
      run_to_halt("R6");
      check("R6", "P after SEC CLC", view_p, 8'h24);
   endtask

   task automatic t_jmp();
      hold_reset();
      poke(16'h200, 8'h4C); poke(16'h201, 8'h34); poke(16'h202, 8'h05);
      poke(16'h534, 8'hA9); poke(16'h535, 8'h77);
      poke(16'h536, 8'h02);
      release_at(16'h0200);
      run_to_halt("R7");
      check("R7", "jump target fetch", f_addr[1], 16'h0534);
      check("R7", "A at target", view_a, 8'h77);
   endtask

   task automatic t_jsr();
      hold_reset();
      poke(16'h200, 8'h20); poke(16'h201, 8'h00); poke(16'h202, 8'h03);
      poke(16'h300, 8'h02);
      release_at(16'h0200);
      run_to_halt("R8");
      check("R8", "target fetch", f_addr[1], 16'h0300);
      check("R8", "push order high", w_addr[0], 16'h01FD);
      check("R8", "push order low", w_addr[1], 16'h01FC);
      check("R8", "stacked high", mem[12'h1FD], 8'h02);
      check("R8", "stacked low", mem[12'h1FC], 8'h03);
      check("R8", "sp", view_sp, 8'hFB);
   endtask

   task automatic t_timing();
      logic [15:0] ea [0:10];
      int          gap [0:9];
      hold_reset();
      poke(16'h200, 8'hA9); poke(16'h201, 8'h01);
      poke(16'h202, 8'h85); poke(16'h203, 8'h10);
      poke(16'h204, 8'h24); poke(16'h205, 8'h10);
      poke(16'h206, 8'hEA);
      poke(16'h207, 8'h38);
      poke(16'h208, 8'h18);
      poke(16'h209, 8'hA2); poke(16'h20A, 8'h02);
      poke(16'h20B, 8'h86); poke(16'h20C, 8'h11);
      poke(16'h20D, 8'h4C); poke(16'h20E, 8'h10); poke(16'h20F, 8'h02);
      poke(16'h210, 8'h20); poke(16'h211, 8'h00); poke(16'h212, 8'h03);
      poke(16'h300, 8'h02);
      ea = '{16'h0200, 16'h0202, 16'h0204, 16'h0206, 16'h0207, 16'h0208,
             16'h0209, 16'h020B, 16'h020D, 16'h0210, 16'h0300};
      gap = '{2, 3, 3, 2, 2, 2, 2, 3, 3, 6};
      release_at(16'h0200);
      run_to_halt("R2");
      check("R2", "fetch count", nf, 11);
      for (int i = 0; i < 11; i++)
         check("R2", $sformatf("fetch %0d addr (length)", i), f_addr[i], ea[i]);
      for (int i = 0; i < 10; i++)
         check("R2", $sformatf("cycles of op %0d", i), f_cyc[i+1] - f_cyc[i], gap[i]);
      check("R8", "stacked high in sequence", mem[12'h1FD], 8'h02);
      check("R8", "stacked low in sequence", mem[12'h1FC], 8'h13);
   endtask

   task automatic t_illegal();
      hold_reset();
      poke(16'h200, 8'hA9); poke(16'h201, 8'h33);
      poke(16'h202, 8'hFF);
      poke(16'h203, 8'hA9); poke(16'h204, 8'h44);
      release_at(16'h0200);
      run_to_halt("R9");
      repeat (30) @(negedge clk);
      check("R9", "still illegal", illegal_op, 1);
      check("R9", "bus accesses while halted", hacc, 0);
      check("R9", "A frozen", view_a, 8'h33);
      check("R9", "P frozen", view_p, 8'h24);
      check("R10", "no extra fetch", nf, 2);
      hold_reset();
      poke(16'h200, 8'hEA); poke(16'h201, 8'h02);
      release_at(16'h0200);
      check("R9", "cleared by reset", illegal_op, 0);
      run_to_halt("R9");
   endtask

   initial begin
      #1_000_000;
      nfail++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      t_reset();
      t_loads();
      t_stores();
      t_bit();
      t_carry();
      t_jmp();
      t_jsr();
      t_timing();
      t_illegal();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule